// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block lays a 64x64 cursor image over an 8-bit indexed pixel stream. Each pixel of the cursor image holds a two-bit code. Code 0 paints the background colour. Code 1 paints the foreground colour. Code 2 lets the screen pixel through unchanged. Code 3 paints the bitwise inverse of the screen pixel. Outside the cursor rectangle, or while the cursor is disabled, the screen pixel passes through. The output is registered, so it lags the pixel and counter inputs by one clock.

Software programs the block through a byte-wide register port. The port sets the split X and Y position fields, the two colours, the control byte and the map base. The cursor image lives in an internal 1 KiB RAM that is loaded through a separate byte write port. That port carries full video-memory byte addresses, and the RAM keeps only those writes that fall inside the 1 KiB window selected by the map base. Position, control and colour writes are held in pending registers and take effect at the next frame-start pulse, which prevents a half-updated cursor from appearing on screen.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted `pix_out` is 0x00. After reset the cursor is disabled, so `pix_out` equals the previous cycle's `pix_in`.
- R2: `pix_out` is registered. It reflects the `pix_x`, `pix_y` and `pix_in` presented one clock earlier. Where the cursor does not cover the pixel, it equals that earlier `pix_in`.
- R3: Without interlace, the cursor covers a pixel when cx <= `pix_x` <= cx+63 and cy <= `pix_y` <= cy+63, where cx and cy are the active cursor X and Y positions.
- R4: Inside the cursor, a code of 0 outputs the background colour and a code of 1 outputs the foreground colour. A code of 2 outputs `pix_in`, and a code of 3 outputs ~`pix_in`.
- R5: Cursor X is 11 bits. Bits 10:3 come from register select 0, and bits 2:0 come from control bits 4:2.
- R6: Cursor Y is 11 bits. Bits 10:9 come from control bits 1:0, bits 8:1 come from register select 1, and bit 0 comes from control bit 6.
- R7: Control bit 5 enables the cursor. When it is clear, every pixel passes through.
- R8: Writes to register selects 0 to 4 are held pending. They take effect only on the clock edge at which `frame_start` is high. Register select 2 is the control byte, select 3 is the foreground colour and select 4 is the background colour.
- R9: With `interlace` high, the cursor covers 128 lines starting at cy, and the map row used is (`pix_y`-cy)/2, so each row is shown twice.
- R10: A map write is stored only when `map_addr[20:10]` equals the map base. Bits 7:0 of the base come from register select 5 and bits 10:8 from select 6, and base writes take effect immediately. Byte offset `map_addr[9:0]` holds map row r, columns 4k to 4k+3, at offset r*16+k. Column 4k+j sits in bits 2j+1:2j of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that makes pending registers active |
| interlace | input | 1 | Double-height cursor when high |
| pix_x | input | 11 | Current horizontal display counter |
| pix_y | input | 11 | Current vertical display counter |
| pix_in | input | 8 | Incoming screen pixel |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 X high, 1 Y high, 2 control, 3 foreground, 4 background, 5 base low, 6 base high) |
| reg_wdata | input | 8 | Register write data |
| map_we | input | 1 | Cursor map byte write strobe |
| map_addr | input | 21 | Video-memory byte address of the map write |
| map_wdata | input | 8 | Map byte (four 2-bit codes) |
| pix_out | output | 8 | Overlaid pixel, one clock after input |

## Verification
The assertions assume that `frame_start` is never high in the same cycle as a register write. They also assume that every map byte the display can reach has been written before the cursor is enabled, so the codes they sample are defined. The bench pulses `frame_start` only in cycles with no register strobe, and it loads all 1024 map bytes before it enables the cursor. The bench also assumes that the counters stay within 0 to 2047, and it places every cursor so that its window fits inside that range.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int PIX_W   = 8;
  localparam int COORD_W = 11;
  localparam int REG_W   = 8;
  localparam int CTRL_W  = 7;
  localparam int BASE_W  = 11;
  localparam int CODE_W  = 2;

  localparam int CTL_EN = 5;
  localparam int CTL_Y0 = 6;

  typedef enum logic [2:0] {
    SEL_XHI     = 3'd0,
    SEL_YHI     = 3'd1,
    SEL_CTRL    = 3'd2,
    SEL_FG      = 3'd3,
    SEL_BG      = 3'd4,
    SEL_BASE_LO = 3'd5,
    SEL_BASE_HI = 3'd6
  } reg_sel_e;

  typedef enum logic [CODE_W-1:0] {
    CODE_BG  = 2'd0,
    CODE_FG  = 2'd1,
    CODE_SCR = 2'd2,
    CODE_INV = 2'd3
  } cur_code_e;

  typedef struct packed {
    logic [REG_W-1:0]  xhi;
    logic [REG_W-1:0]  yhi;
    logic [CTRL_W-1:0] ctrl;
    logic [PIX_W-1:0]  fg;
    logic [PIX_W-1:0]  bg;
  } cur_regs_t;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               frame_start,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  output logic               cur_en,
  output logic [PIX_W-1:0]   fg,
  output logic [PIX_W-1:0]   bg,
  output logic [BASE_W-1:0]  map_base
);
  cur_regs_t pend_q, pend_d;
  cur_regs_t act_q;
  logic [BASE_W-1:0] base_q, base_d;
  logic pend_en, base_en, act_en;

  always_comb begin
    pend_d  = pend_q;
    base_d  = base_q;
    pend_en = 1'b0;
    base_en = 1'b0;
    if (reg_we) begin
      case (reg_sel_e'(reg_sel))
        SEL_XHI:     begin pend_d.xhi  = reg_wdata;             pend_en = 1'b1; end
        SEL_YHI:     begin pend_d.yhi  = reg_wdata;             pend_en = 1'b1; end
        SEL_CTRL:    begin pend_d.ctrl = reg_wdata[CTRL_W-1:0]; pend_en = 1'b1; end
        SEL_FG:      begin pend_d.fg   = reg_wdata;             pend_en = 1'b1; end
        SEL_BG:      begin pend_d.bg   = reg_wdata;             pend_en = 1'b1; end
        SEL_BASE_LO: begin base_d[REG_W-1:0] = reg_wdata;       base_en = 1'b1; end
        SEL_BASE_HI: begin
          base_d[BASE_W-1:REG_W] = reg_wdata[BASE_W-REG_W-1:0];
          base_en = 1'b1;
        end
        default: ;
      endcase
    end
    act_en = frame_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      base_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (base_en) base_q <= base_d;
      if (act_en)  act_q  <= pend_q;
    end
  end

  assign cur_x    = {act_q.xhi, act_q.ctrl[4:2]};
  assign cur_y    = {act_q.ctrl[1:0], act_q.yhi, act_q.ctrl[CTL_Y0]};
  assign cur_en   = act_q.ctrl[CTL_EN];
  assign fg       = act_q.fg;
  assign bg       = act_q.bg;
  assign map_base = base_q;
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_pkg::*;
#(
  parameter int CUR_DIM = 64,
  localparam int IDX_W = $clog2(CUR_DIM)
)(
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic               cur_en,
  input  logic               interlace,
  output logic               hit,
  output logic [IDX_W-1:0]   col,
  output logic [IDX_W-1:0]   row
);
  localparam int CW1 = COORD_W + 1;
  localparam logic [COORD_W:0] SPAN1 = CW1'(CUR_DIM);
  localparam logic [COORD_W:0] SPAN2 = CW1'(2 * CUR_DIM);

  logic [COORD_W:0] dx, dy, span_y;
  logic in_x, in_y;

  always_comb begin
    dx     = {1'b0, pix_x} - {1'b0, cur_x};
    dy     = {1'b0, pix_y} - {1'b0, cur_y};
    span_y = interlace ? SPAN2 : SPAN1;
    in_x   = !dx[COORD_W] && (dx < SPAN1);
    in_y   = !dy[COORD_W] && (dy < span_y);
    hit    = cur_en && in_x && in_y;
    col    = dx[IDX_W-1:0];
    row    = interlace ? dy[IDX_W:1] : dy[IDX_W-1:0];
  end
endmodule

// File: rtl/cursor_map_ram.sv
module cursor_map_ram
  import cursor_pkg::*;
#(
  parameter int CUR_DIM = 64,
  localparam int IDX_W = $clog2(CUR_DIM),
  localparam int PPB = REG_W / CODE_W,
  localparam int DEPTH = CUR_DIM * CUR_DIM / PPB,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int MAP_ADDR_W = OFF_W + BASE_W
)(
  input  logic                  clk,
  input  logic                  map_we,
  input  logic [MAP_ADDR_W-1:0] map_addr,
  input  logic [REG_W-1:0]      map_wdata,
  input  logic [BASE_W-1:0]     map_base,
  input  logic [IDX_W-1:0]      rd_row,
  input  logic [IDX_W-1:0]      rd_col,
  output logic [CODE_W-1:0]     code
);
  logic [REG_W-1:0] mem [DEPTH];
  logic             wr_ok;
  logic [OFF_W-1:0] rd_off;
  logic [REG_W-1:0] rd_byte;

  always_comb begin
    wr_ok   = map_we && (map_addr[MAP_ADDR_W-1:OFF_W] == map_base);
    rd_off  = {rd_row, rd_col[IDX_W-1:2]};
    rd_byte = mem[rd_off];
    code    = rd_byte[{rd_col[1:0], 1'b0} +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[map_addr[OFF_W-1:0]] <= map_wdata;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CUR_DIM = 64,
  localparam int IDX_W = $clog2(CUR_DIM),
  localparam int OFF_W = 2 * IDX_W - 2,
  localparam int MAP_ADDR_W = OFF_W + BASE_W
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  interlace,
  input  logic [COORD_W-1:0]    pix_x,
  input  logic [COORD_W-1:0]    pix_y,
  input  logic [PIX_W-1:0]      pix_in,
  input  logic                  reg_we,
  input  logic [2:0]            reg_sel,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic                  map_we,
  input  logic [MAP_ADDR_W-1:0] map_addr,
  input  logic [REG_W-1:0]      map_wdata,
  output logic [PIX_W-1:0]      pix_out
);
  logic [COORD_W-1:0] cur_x, cur_y;
  logic               cur_en;
  logic [PIX_W-1:0]   fg_act, bg_act;
  logic [BASE_W-1:0]  map_base;
  logic               hit;
  logic [IDX_W-1:0]   col, row;
  logic [CODE_W-1:0]  code;
  logic [PIX_W-1:0]   out_d, out_q;

  cursor_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_start(frame_start),
    .cur_x(cur_x), .cur_y(cur_y), .cur_en(cur_en),
    .fg(fg_act), .bg(bg_act), .map_base(map_base)
  );

  cursor_window #(.CUR_DIM(CUR_DIM)) u_win (
    .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
    .cur_en(cur_en), .interlace(interlace),
    .hit(hit), .col(col), .row(row)
  );

  cursor_map_ram #(.CUR_DIM(CUR_DIM)) u_map (
    .clk(clk), .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata),
    .map_base(map_base), .rd_row(row), .rd_col(col), .code(code)
  );

  always_comb begin
    out_d = pix_in;
    if (hit) begin
      case (cur_code_e'(code))
        CODE_BG:  out_d = bg_act;
        CODE_FG:  out_d = fg_act;
        CODE_SCR: out_d = pix_in;
        CODE_INV: out_d = ~pix_in;
        default:  out_d = pix_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pix_out = out_q;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic [7:0]  pix_in,
  input logic [7:0]  pix_out,
  input logic        hit,
  input logic [1:0]  code,
  input logic [7:0]  fg,
  input logic [10:0] cur_x,
  input logic        cur_en
);
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> pix_out == $past(pix_in));

  a_r4_foreground: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && code == 2'd1) |=> pix_out == $past(fg));

  a_r4_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && code == 2'd3) |=> pix_out == ~$past(pix_in));

  a_r4_screen: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && code == 2'd2) |=> pix_out == $past(pix_in));

  a_r8_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_x));

  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |-> !hit);
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_in(pix_in),
  .pix_out(pix_out), .hit(hit), .code(code), .fg(fg_act),
  .cur_x(cur_x), .cur_en(cur_en)
);

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n, frame_start, interlace;
  logic [10:0] pix_x, pix_y;
  logic [7:0]  pix_in, pix_out;
  logic        reg_we, map_we;
  logic [2:0]  reg_sel;
  logic [7:0]  reg_wdata, map_wdata;
  logic [20:0] map_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  p_xhi, p_yhi, p_ctrl, p_fg, p_bg;
  logic [7:0]  a_xhi, a_yhi, a_ctrl, a_fg, a_bg;
  logic [10:0] m_base;
  logic [7:0]  m_map [1024];

  always #2 clk = ~clk;

  cursor_overlay u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .interlace(interlace),
    .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata),
    .pix_out(pix_out)
  );

  function automatic logic [7:0] model_out(input int x, input int y, input logic [7:0] p);
    int cx, cy, dx, dy, rows, row, sh;
    logic [7:0] b;
    logic [1:0] c;
    cx = a_xhi * 8 + int'(a_ctrl[4:2]);
    cy = int'(a_ctrl[1:0]) * 512 + a_yhi * 2 + int'(a_ctrl[6]);
    dx = x - cx;
    dy = y - cy;
    rows = interlace ? 128 : 64;
    if (!a_ctrl[5] || dx < 0 || dx >= 64 || dy < 0 || dy >= rows) return p;
    row = interlace ? dy / 2 : dy;
    b = m_map[row * 16 + dx / 4];
    sh = 2 * (dx % 4);
    c = 2'((b >> sh) & 8'h3);
    case (c)
      2'd0: return a_bg;
      2'd1: return a_fg;
      2'd2: return p;
      default: return ~p;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      3'd0: p_xhi = d;
      3'd1: p_yhi = d;
      3'd2: p_ctrl = {1'b0, d[6:0]};
      3'd3: p_fg = d;
      3'd4: p_bg = d;
      3'd5: m_base[7:0] = d;
      3'd6: m_base[10:8] = d[2:0];
      default: ;
    endcase
  endtask

  task automatic wr_map(input logic [20:0] a, input logic [7:0] d);
    map_we = 1'b1; map_addr = a; map_wdata = d;
    @(negedge clk);
    map_we = 1'b0;
    if (a[20:10] == m_base) m_map[a[9:0]] = d;
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    a_xhi = p_xhi; a_yhi = p_yhi; a_ctrl = p_ctrl; a_fg = p_fg; a_bg = p_bg;
  endtask

  task automatic probe(input string tag, input int x, input int y);
    logic [7:0] p, e;
    p = 8'((x * 7 + y * 13) & 255);
    pix_x = 11'(x); pix_y = 11'(y); pix_in = p;
    e = model_out(x, y, p);
    @(negedge clk);
    check(tag, pix_out, e);
  endtask

  task automatic set_pos(input int cx, input int cy, input bit en);
    wr_reg(3'd0, 8'(cx / 8));
    wr_reg(3'd1, 8'((cy / 2) % 256));
    wr_reg(3'd2, {1'b0, 1'(cy % 2), en, 3'(cx % 8), 2'(cy / 512)});
  endtask

  // R1: reset state and pass-through after reset
  task automatic t_reset();
    rst_n = 1'b0;
    pix_in = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1 reset output", pix_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R1 disabled after reset", 100, 50);
    probe("R1 disabled after reset", 5, 7);
  endtask

  // R10: map load, base filtering
  task automatic t_map_load();
    wr_reg(3'd5, 8'd5);
    wr_reg(3'd6, 8'd0);
    for (int i = 0; i < 1024; i++)
      wr_map({11'd5, 10'(i)}, 8'((i * 37 + 11) & 255));
    wr_map({11'd6, 10'd0}, 8'hFF);   // outside window: must be ignored
    wr_map({11'd4, 10'd1}, 8'hFF);
  endtask

  // R8: pending values not visible before frame start
  task automatic t_shadow();
    set_pos(100, 50, 1'b1);
    wr_reg(3'd3, 8'hA5);
    wr_reg(3'd4, 8'h3C);
    probe("R8 pending before frame", 100, 50);
    probe("R8 pending before frame", 110, 60);
    pulse_frame();
    probe("R8 active after frame", 100, 50);
  endtask

  // R3 R4: full window scan with a margin of one pixel
  task automatic t_scan();
    for (int y = 49; y <= 114; y++)
      for (int x = 99; x <= 164; x++)
        probe("R3 R4 window scan", x, y);
  endtask

  // R10: immediate base change, write lands in new window
  task automatic t_base_switch();
    probe("R10 ignored wrong-base byte", 100, 50);
    probe("R10 ignored wrong-base byte", 104, 50);
    wr_reg(3'd5, 8'd6);
    wr_map({11'd6, 10'd0}, 8'h55);
    probe("R10 base immediate", 100, 50);
    probe("R10 base immediate", 103, 50);
    wr_map({11'd5, 10'd0}, 8'hAA);   // old window now ignored
    probe("R10 old base ignored", 101, 50);
  endtask

  // R5 R6: odd position fields in all parts
  task automatic t_corners();
    set_pos(1234, 777, 1'b1);
    pulse_frame();
    probe("R5 left edge in", 1234, 790);
    probe("R5 left edge out", 1233, 790);
    probe("R5 right edge in", 1297, 790);
    probe("R5 right edge out", 1298, 790);
    probe("R6 top edge in", 1240, 777);
    probe("R6 top edge out", 1240, 776);
    probe("R6 bottom edge in", 1240, 840);
    probe("R6 bottom edge out", 1240, 841);
    for (int x = 1234; x < 1242; x++) probe("R6 first row", x, 777);
  endtask

  // R7: enable bit
  task automatic t_disable();
    set_pos(1234, 777, 1'b0);
    pulse_frame();
    for (int x = 1234; x < 1242; x++) probe("R7 disabled in window", x, 780);
    set_pos(100, 50, 1'b1);
    pulse_frame();
    probe("R7 enabled again", 101, 50);
  endtask

  // R9: interlace double height
  task automatic t_interlace();
    interlace = 1'b1;
    for (int y = 49; y <= 178; y++) begin
      probe("R9 interlace", 100, y);
      probe("R9 interlace", 102, y);
      probe("R9 interlace", 163, y);
      probe("R9 interlace", 164, y);
    end
    interlace = 1'b0;
    probe("R9 back to single height", 101, 114);
  endtask

  // R8: colour change waits for frame start
  task automatic t_colour_shadow();
    wr_reg(3'd3, 8'h0F);
    probe("R8 old fg kept", 100, 50);
    pulse_frame();
    probe("R8 new fg", 100, 50);
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; interlace = 1'b0;
    pix_x = '0; pix_y = '0; pix_in = '0;
    reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    map_we = 1'b0; map_addr = '0; map_wdata = '0;
    p_xhi = 0; p_yhi = 0; p_ctrl = 0; p_fg = 0; p_bg = 0;
    a_xhi = 0; a_yhi = 0; a_ctrl = 0; a_fg = 0; a_bg = 0;
    m_base = '0;
    for (int i = 0; i < 1024; i++) m_map[i] = 8'h00;
    @(negedge clk);
    t_reset();
    t_map_load();
    t_shadow();
    t_scan();
    t_base_switch();
    t_corners();
    t_disable();
    t_interlace();
    t_colour_shadow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule